// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N and emits a pulse one input cycle wide once per N input cycles. The pulse is meant to feed a phase/frequency detector. Inside, a digital model of a dual-modulus prescaler divides by either M or M+1. Two down-counters sit behind it. The main counter counts B prescaler cycles per output period. The swallow counter holds the prescaler at M+1 for the first A of those cycles, so N = M·B + A.

Software writes a new configuration by presenting the modulus select, the swallow count A and the main count B, then raising the load strobe for one clock. The block captures these values into shadow registers. The running output period always finishes with the ratio it started with. The new ratio applies from the next period boundary. A configuration that cannot give a defined ratio is rejected: the previous ratio stays in force and an error flag is raised. The analog prescaler input stage and the reference-side divider are not part of this block.

Top module: `swallow_divider`

## Requirements
- R1: With a valid configuration active, rising pulses on `div_pulse` are exactly N = M·B + A input clocks apart. M is 32 when the modulus select is 0 and 64 when it is 1; A is the 7-bit swallow count (0..127) and B is the 11-bit main count.
- R2: Every output pulse is high for exactly one input clock cycle.
- R3: A load (the strobe high at a rising clock edge) captures the modulus select, A and B. The output period running at that edge completes with the old ratio, and every period after the next pulse uses the new ratio.
- R4: Changes on the modulus select, swallow or main inputs while the load strobe is low have no effect on the output period.
- R5: A load with B < A, or with B < 3, is rejected. The active ratio is kept, and `cfg_err` reads 1 from the clock after that load.
- R6: `cfg_err` changes only at a load: an accepted load clears it, and between loads it holds its value.
- R7: While reset is asserted, `div_pulse` and `cfg_err` are 0. Reset installs the default configuration (modulus select 0, A = 0, B = 3), which gives N = 96 until the first accepted load takes effect.
- R8: The extreme swallow settings are exact: A = 0 gives N = M·B, and A = B gives N = (M+1)·B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode64 | input | 1 | Modulus select: 0 selects 32/33, 1 selects 64/65 |
| swallow_in | input | 7 | Swallow count A |
| main_in | input | 11 | Main count B |
| load | input | 1 | Capture strobe for the three configuration inputs |
| div_pulse | output | 1 | Divided output pulse, one clock wide |
| cfg_err | output | 1 | Last load was rejected as invalid |

## Verification
The bench sweeps every swallow value from 0 up to B for small main counts in both modulus modes, plus a few large settings, and checks each measured period against M·B + A. An off-by-one in the swallow chain would show up as a period shifted by one at A = 0 or A = B. The bench loads each new setting partway through a period and checks that this period still has the old length. A design that reloaded at once would give a truncated or mixed period there. It also scrambles the inputs without a load, and tries settings with B < A or B < 3. A design that leaked unloaded inputs, or accepted a bad setting, would change the period or leave the error flag wrong.

// File: rtl/pds_pkg.sv
package pds_pkg;
   typedef enum logic {
      PDS_MOD_LO = 1'b0,
      PDS_MOD_HI = 1'b1
   } pds_mod_e;

   localparam int PDS_MIN_MAIN = 3;

   function automatic int unsigned pds_base(input pds_mod_e sel, input int unsigned lo,
                                            input int unsigned hi);
      return (sel == PDS_MOD_HI) ? hi : lo;
   endfunction
endpackage

// File: rtl/pds_cfg.sv
module pds_cfg
   import pds_pkg::*;
#(
   parameter int A_W      = 7,
   parameter int B_W      = 11,
   parameter bit RST_MODE = 1'b0,
   parameter int RST_A    = 0,
   parameter int RST_B    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  pds_mod_e       mode_in,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   output pds_mod_e       mode_q,
   output logic [A_W-1:0] a_q,
   output logic [B_W-1:0] b_q,
   output logic           cfg_err
);
   logic accept;

   always_comb begin
      accept = (b_in >= B_W'(a_in)) && (b_in >= B_W'(PDS_MIN_MAIN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= pds_mod_e'(RST_MODE);
         a_q     <= A_W'(RST_A);
         b_q     <= B_W'(RST_B);
         cfg_err <= 1'b0;
      end else if (load) begin
         cfg_err <= !accept;
         if (accept) begin
            mode_q <= mode_in;
            a_q    <= a_in;
            b_q    <= b_in;
         end
      end
   end
endmodule

// File: rtl/pds_chain.sv
module pds_chain
   import pds_pkg::*;
#(
   parameter int A_W      = 7,
   parameter int B_W      = 11,
   parameter bit RST_MODE = 1'b0,
   parameter int RST_A    = 0,
   parameter int RST_B    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pre_tc,
   input  pds_mod_e       mode_q,
   input  logic [A_W-1:0] a_q,
   input  logic [B_W-1:0] b_q,
   output logic           end_cycle,
   output logic           swal_next,
   output pds_mod_e       mode_next,
   output logic [B_W-1:0] main_left
);
   logic [A_W-1:0] sc_q, sc_d;
   logic [B_W-1:0] mc_q, mc_d;
   pds_mod_e       md_q;

   always_comb begin
      end_cycle = pre_tc && (mc_q == B_W'(1));
      sc_d      = sc_q;
      mc_d      = mc_q;
      mode_next = md_q;
      if (end_cycle) begin
         sc_d      = a_q;
         mc_d      = b_q;
         mode_next = mode_q;
      end else if (pre_tc) begin
         mc_d = mc_q - B_W'(1);
         sc_d = (sc_q == '0) ? '0 : sc_q - A_W'(1);
      end
      swal_next = (sc_d != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q <= A_W'(RST_A);
         mc_q <= B_W'(RST_B);
         md_q <= pds_mod_e'(RST_MODE);
      end else begin
         sc_q <= sc_d;
         mc_q <= mc_d;
         md_q <= mode_next;
      end
   end

   assign main_left = mc_q;
endmodule

// File: rtl/pds_prescaler.sv
module pds_prescaler
   import pds_pkg::*;
#(
   parameter int PRE_LO   = 32,
   parameter int PRE_HI   = 64,
   parameter bit RST_MODE = 1'b0,
   parameter int RST_A    = 0,
   localparam int PC_W    = $clog2(PRE_HI + 1)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pds_mod_e mode_next,
   input  logic     swal_next,
   output logic     pre_tc
);
   localparam int RST_PC = pds_base(pds_mod_e'(RST_MODE), PRE_LO, PRE_HI) - 1
                           + ((RST_A != 0) ? 1 : 0);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] reload;

   always_comb begin
      pre_tc = (pc_q == '0);
      reload = PC_W'(pds_base(mode_next, PRE_LO, PRE_HI)) - PC_W'(1) + PC_W'(swal_next);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_q <= PC_W'(RST_PC);
      else if (pre_tc) pc_q <= reload;
      else             pc_q <= pc_q - PC_W'(1);
   end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
   import pds_pkg::*;
#(
   parameter int A_W      = 7,
   parameter int B_W      = 11,
   parameter int PRE_LO   = 32,
   parameter int PRE_HI   = 64,
   parameter bit OUT_REG  = 1'b1,
   parameter bit RST_MODE = 1'b0,
   parameter int RST_A    = 0,
   parameter int RST_B    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mode64,
   input  logic [A_W-1:0] swallow_in,
   input  logic [B_W-1:0] main_in,
   input  logic           load,
   output logic           div_pulse,
   output logic           cfg_err
);
   if (B_W < A_W)                     $error("main count narrower than swallow count");
   if (PRE_LO < 2 || PRE_HI < PRE_LO) $error("prescaler moduli out of order");
   if (RST_B < PDS_MIN_MAIN || RST_B < RST_A) $error("reset configuration invalid");
   if (RST_B >= (1 << B_W) || RST_A >= (1 << A_W)) $error("reset counts exceed widths");

   pds_mod_e       mode_q, mode_next;
   logic [A_W-1:0] cfg_a;
   logic [B_W-1:0] cfg_b;
   logic [B_W-1:0] main_left;
   logic           pre_tc, end_cycle, swal_next;

   pds_cfg #(.A_W(A_W), .B_W(B_W), .RST_MODE(RST_MODE), .RST_A(RST_A), .RST_B(RST_B)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(load), .mode_in(pds_mod_e'(mode64)),
      .a_in(swallow_in), .b_in(main_in),
      .mode_q(mode_q), .a_q(cfg_a), .b_q(cfg_b), .cfg_err(cfg_err)
   );

   pds_chain #(.A_W(A_W), .B_W(B_W), .RST_MODE(RST_MODE), .RST_A(RST_A), .RST_B(RST_B)) u_chain (
      .clk(clk), .rst_n(rst_n), .pre_tc(pre_tc), .mode_q(mode_q), .a_q(cfg_a), .b_q(cfg_b),
      .end_cycle(end_cycle), .swal_next(swal_next), .mode_next(mode_next), .main_left(main_left)
   );

   pds_prescaler #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .RST_MODE(RST_MODE), .RST_A(RST_A)) u_pre (
      .clk(clk), .rst_n(rst_n), .mode_next(mode_next), .swal_next(swal_next), .pre_tc(pre_tc)
   );

   if (OUT_REG) begin : g_out_reg
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= end_cycle;
      end
      assign div_pulse = pulse_q;
   end else begin : g_out_comb
      assign div_pulse = end_cycle;
   end
endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
   parameter int A_W     = 7,
   parameter int B_W     = 11,
   parameter bit OUT_REG = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           load,
   input logic           div_pulse,
   input logic           cfg_err,
   input logic           pre_tc,
   input logic           end_cycle,
   input logic [B_W-1:0] main_left,
   input logic [A_W-1:0] cfg_a,
   input logic [B_W-1:0] cfg_b
);
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse); // R2

   if (OUT_REG) begin : g_reg
      AST_PULSE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
         div_pulse |-> $past(end_cycle)); // R1
   end else begin : g_comb
      AST_PULSE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
         div_pulse |-> pre_tc); // R1
   end

   AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      main_left != '0); // R1

   AST_ERR_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_err)); // R6

   AST_CFG_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_b >= B_W'(cfg_a)) && (cfg_b >= B_W'(3))); // R5
endmodule

bind swallow_divider pds_chk #(.A_W(A_W), .B_W(B_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .load(load), .div_pulse(div_pulse), .cfg_err(cfg_err),
   .pre_tc(pre_tc), .end_cycle(end_cycle), .main_left(main_left),
   .cfg_a(cfg_a), .cfg_b(cfg_b)
);

// File: tb/swallow_divider_tb.sv
`timescale 1ns/1ps
module swallow_divider_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode64 = 1'b0;
   logic [6:0]  swallow_in = '0;
   logic [10:0] main_in = 11'd3;
   logic        load = 1'b0;
   logic        div_pulse, cfg_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0, lastc = 0, per = 0;
   bit prev_p = 1'b0;
   int cur_n = 96;
   event ev_pulse;

   always #2 clk = ~clk;

   swallow_divider u_dut (
      .clk(clk), .rst_n(rst_n), .mode64(mode64), .swallow_in(swallow_in),
      .main_in(main_in), .load(load), .div_pulse(div_pulse), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (prev_p) check(!div_pulse, "R2 pulse width", 2, 1);
         if (div_pulse) begin
            per   = cyc - lastc;
            lastc = cyc;
            -> ev_pulse;
         end
         prev_p = div_pulse;
      end
   end

   task automatic run_cfg(input bit md, input int a, input int b);
      bit valid;
      int n_new;
      valid = (b >= a) && (b >= 3);
      n_new = (md ? 64 : 32) * b + a;
      @(ev_pulse);
      mode64 = md; swallow_in = 7'(a); main_in = 11'(b); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      if (valid) check(cfg_err == 1'b0, "R6 accepted load clears flag", int'(cfg_err), 0);
      else       check(cfg_err == 1'b1, "R5 rejected load flags error", int'(cfg_err), 1);
      mode64 = ~md; swallow_in = 7'(a) ^ 7'h55; main_in = 11'(b) + 11'd9;  // R4 no load
      @(ev_pulse);
      check(per == cur_n, "R3 running period keeps old ratio", per, cur_n);
      if (valid) cur_n = n_new;
      @(ev_pulse);
      if (a == 0 || a == b) check(per == cur_n, "R8 swallow extreme", per, cur_n);
      else if (valid)       check(per == cur_n, "R1 period M*B+A", per, cur_n);
      else                  check(per == cur_n, "R5 ratio kept after reject", per, cur_n);
      check(per == cur_n, "R4 unloaded inputs ignored", per, cur_n);
      check(cfg_err == !valid, "R6 flag holds between loads", int'(cfg_err), int'(!valid));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(div_pulse == 1'b0, "R7 pulse low in reset", int'(div_pulse), 0);
      check(cfg_err == 1'b0, "R7 flag low in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      // R7: first checked period is the default ratio 96
      for (int md = 0; md < 2; md++)
         for (int b = 3; b <= 6; b++)
            for (int a = 0; a <= b; a++)
               run_cfg(md[0], a, b);
      run_cfg(1'b0, 127, 127);
      run_cfg(1'b1, 40, 40);
      run_cfg(1'b0, 0, 100);
      run_cfg(1'b0, 5, 4);
      run_cfg(1'b1, 0, 2);
      run_cfg(1'b0, 127, 126);
      run_cfg(1'b1, 10, 20);
      run_cfg(1'b0, 17, 33);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule